// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is the command state machine inside a behavioural model of a parallel NOR-style flash device. It watches qualified write cycles, each an address plus a data byte, and recognises the multi-cycle unlock sequences that start a program, a sector erase or a chip erase. It also recognises the sequences that enter the identification (autoselect) view, suspend or resume an erase, and reset. From these it decides what a read returns: the array, the status word, or the identification data. It reports this on `rd_sel`.

Program and erase are modelled as embedded operations of fixed length, each timed by its own countdown. While a countdown runs, `busy` is high and reads return status. A test input can force the running operation to time out. This latches a fault that only a reset write clears. An erase can be paused. While it is paused, reads inside the erased sector (or any sector, for a chip erase) return status, and reads elsewhere return the array. A program may run inside the pause.

Unlock cycles compare the low 11 address bits. Sectors are the top `SECT_W` address bits.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `rd_sel` is 0 (array), `busy`, `op_fault` and `erase_held` are 0, and no command is needed to read the array.
- R2: Writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then one write at any address start a program. During the program `busy`=1 and `rd_sel`=1 (status) for exactly PROG_CYC cycles after the last write, and then the block returns to `rd_sel`=0 on its own.
- R3: A write with a wrong address or data, or one out of order, abandons the sequence in progress. A later command needs the full sequence again, and `rd_sel` stays 0.
- R4: A write of data 0xF0 at any address abandons any unfinished sequence and leaves `rd_sel`=0. This includes the write that would have carried the program data.
- R5: A 0xF0 write during a running program or erase is ignored: `busy` stays 1 and the duration is unchanged.
- R6: Unlock then 0x90@0x555 selects `rd_sel`=2 (identification). Every write other than 0xF0 leaves it there, including a complete program sequence. A 0xF0 write returns `rd_sel` to 0.
- R7: Asserting `force_timeout` during a running operation stops it: `busy`=0, `op_fault`=1, `rd_sel`=1. All writes other than 0xF0 are ignored. A 0xF0 write clears the fault and restores `rd_sel`=0.
- R8: Unlock, 0x80@0x555, unlock, then either 0x30 at any address in the target sector (sector erase) or 0x10@0x555 (chip erase) gives `busy`=1 for exactly ERASE_CYC cycles.
- R9: Unlock then 0xB0@0x555 during an erase pauses it: `busy`=0 and `erase_held`=1. `rd_sel` is 1 for reads in the erased sector (any sector after a chip erase) and 0 elsewhere.
- R10: Unlock then 0x30@0x555 while an erase is paused resumes it. The erase stays busy only for the cycles it had left, so the busy time before and after the pause adds up to ERASE_CYC.
- R11: A program started during an erase pause runs for PROG_CYC cycles. Afterwards the pause and its per-sector read split remain.
- R12: On a cycle where an operation would complete and `force_timeout` is high, the fault wins. On a cycle where an erase completes and a pause command arrives, the completion wins and no pause is recorded.
- R13: While an erase is paused, further erase commands are ignored. Identification can be entered, and a 0xF0 write returns to the paused state rather than leaving it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One qualified write cycle this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| rd_sect | input | SECT_W | Sector of the address currently being read |
| force_timeout | input | 1 | Test input: make the running operation time out |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 identification |
| busy | output | 1 | Embedded program or erase is running |
| op_fault | output | 1 | Timed-out operation latched until reset write |
| erase_held | output | 1 | An erase is paused |

## Verification
Two pairs of events can collide in one cycle: a running operation reaching its final count while the timeout is forced, and an erase finishing on the very edge that accepts a pause command. The bench counts cycles from the start write so that `force_timeout`, or the final write of the pause sequence, lands exactly on the completing edge. It then judges the outcome at the ports. For the first pair it expects `op_fault`=1 with status reads. For the second it expects an idle, unpaused block that returns array data for the erased sector.

// File: rtl/flash_cmd_pkg.sv
// Shared types and command codes for the flash command controller.
// Assumes byte-wide command data and 11-bit unlock address compares.
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2
    } rd_sel_e;

    typedef enum logic [2:0] {
        M_READ, M_IDENT, M_PBUSY, M_EBUSY, M_FAULT
    } mode_e;

    typedef enum logic [2:0] {
        Q_IDLE, Q_KEY1, Q_CMD, Q_PDATA, Q_EKEY0, Q_EKEY1, Q_ECMD
    } step_e;

    typedef struct packed {
        logic reset;
        logic bad;
        logic prog;
        logic sect_erase;
        logic chip_erase;
        logic ident;
        logic susp;
        logic resume;
    } cmd_t;

    localparam int KEY_W = 11;
    localparam logic [KEY_W-1:0] A_KEY_A = 11'h555;
    localparam logic [KEY_W-1:0] A_KEY_B = 11'h2AA;

    localparam logic [7:0] D_KEY_A  = 8'hAA;
    localparam logic [7:0] D_KEY_B  = 8'h55;
    localparam logic [7:0] D_PROG   = 8'hA0;
    localparam logic [7:0] D_ERSU   = 8'h80;
    localparam logic [7:0] D_IDENT  = 8'h90;
    localparam logic [7:0] D_SUSP   = 8'hB0;
    localparam logic [7:0] D_RESUME = 8'h30;
    localparam logic [7:0] D_SECT   = 8'h30;
    localparam logic [7:0] D_CHIP   = 8'h10;
    localparam logic [7:0] D_RESET  = 8'hF0;

endpackage

// File: rtl/flash_seq_tracker.sv
// Tracks unlock and command write sequences and emits one-cycle
// command pulses on the write that completes a sequence.
// Assumes callers decide whether a pulse is honoured in the current mode.
module flash_seq_tracker
    import flash_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] key_addr,
    input  logic [7:0]       wr_data,
    output cmd_t             cmd
);

    step_e step, step_nxt;
    logic  at_a, at_b, key_a, key_b;

    // Decode the two unlock write patterns.
    always_comb begin
        at_a  = (key_addr == A_KEY_A);
        at_b  = (key_addr == A_KEY_B);
        key_a = at_a && (wr_data == D_KEY_A);
        key_b = at_b && (wr_data == D_KEY_B);
    end

    // Next-step and command-pulse decode for one write.
    always_comb begin
        cmd      = '0;
        step_nxt = step;
        if (wr_en) begin
            if (wr_data == D_RESET) begin
                cmd.reset = 1'b1;
                step_nxt  = Q_IDLE;
            end else begin
                step_nxt = Q_IDLE;
                case (step)
                    Q_IDLE:  if (key_a) step_nxt = Q_KEY1; else cmd.bad = 1'b1;
                    Q_KEY1:  if (key_b) step_nxt = Q_CMD;  else cmd.bad = 1'b1;
                    Q_CMD: begin
                        if (at_a && wr_data == D_PROG)        step_nxt = Q_PDATA;
                        else if (at_a && wr_data == D_ERSU)   step_nxt = Q_EKEY0;
                        else if (at_a && wr_data == D_IDENT)  cmd.ident  = 1'b1;
                        else if (at_a && wr_data == D_SUSP)   cmd.susp   = 1'b1;
                        else if (at_a && wr_data == D_RESUME) cmd.resume = 1'b1;
                        else                                  cmd.bad    = 1'b1;
                    end
                    Q_PDATA: cmd.prog = 1'b1;
                    Q_EKEY0: if (key_a) step_nxt = Q_EKEY1; else cmd.bad = 1'b1;
                    Q_EKEY1: if (key_b) step_nxt = Q_ECMD;  else cmd.bad = 1'b1;
                    Q_ECMD: begin
                        if (wr_data == D_SECT)              cmd.sect_erase = 1'b1;
                        else if (at_a && wr_data == D_CHIP) cmd.chip_erase = 1'b1;
                        else                                cmd.bad        = 1'b1;
                    end
                    default: cmd.bad = 1'b1;
                endcase
            end
        end
    end

    // Sequence step register.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= Q_IDLE;
        else        step <= step_nxt;
    end

    // R4: a reset write always leaves the tracker at the start.
    a_r4_reset_clears_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == D_RESET) |=> (step == Q_IDLE));

endmodule

// File: rtl/flash_op_timer.sv
// Fixed-length countdown for one embedded operation, with pause and a
// forced-timeout input. done/tmo are same-cycle pulses on the final edge.
// Assumes DUR >= 1; start takes priority over everything else.
module flash_op_timer #(
    parameter int DUR   = 8,
    localparam int CNT_W = $clog2(DUR + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    input  logic force_to,
    output logic run,
    output logic done,
    output logic tmo
);

    logic [CNT_W-1:0] cnt;
    logic             live;

    // Completion and timeout pulses, only while counting.
    always_comb begin
        live = run && !hold;
        tmo  = live && force_to;
        done = live && !force_to && (cnt == CNT_W'(1));
    end

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(DUR);
        end else if (live) begin
            if (tmo || done) run <= 1'b0;
            else             cnt <= cnt - CNT_W'(1);
        end
    end

    // R10: a paused count keeps its remaining value.
    a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold && !start) |=> (run && $stable(cnt)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command controller top: interprets tracker pulses by mode,
// runs program/erase timers, handles erase pause, faults and read source.
// Assumes writes arrive already qualified, at most one per clock.
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SECT_W    = 3,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20,
    localparam int SECT_LSB = ADDR_W - SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [SECT_W-1:0] rd_sect,
    input  logic              force_timeout,
    output logic [1:0]        rd_sel,
    output logic              busy,
    output logic              op_fault,
    output logic              erase_held
);

    cmd_t              cmd;
    mode_e             st;
    logic              held;
    logic [SECT_W-1:0] ers_sect;
    logic              ers_all;
    logic              p_start, p_run, p_done, p_tmo;
    logic              e_start, e_hold, e_run, e_done, e_tmo;
    logic              ers_cmd;

    flash_seq_tracker u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .key_addr (wr_addr[KEY_W-1:0]),
        .wr_data  (wr_data),
        .cmd      (cmd)
    );

    // Timer controls derived from mode and command pulses.
    always_comb begin
        ers_cmd = cmd.sect_erase || cmd.chip_erase;
        p_start = (st == M_READ) && cmd.prog;
        e_start = (st == M_READ) && !cmd.prog && !held && ers_cmd;
        e_hold  = (st != M_EBUSY);
    end

    flash_op_timer #(.DUR(PROG_CYC)) u_ptim (
        .clk (clk), .rst_n (rst_n), .start (p_start), .hold (1'b0),
        .force_to (force_timeout), .run (p_run), .done (p_done), .tmo (p_tmo)
    );

    flash_op_timer #(.DUR(ERASE_CYC)) u_etim (
        .clk (clk), .rst_n (rst_n), .start (e_start), .hold (e_hold),
        .force_to (force_timeout), .run (e_run), .done (e_done), .tmo (e_tmo)
    );

    // Mode state machine, pause flag and erase target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= M_READ;
            held     <= 1'b0;
            ers_sect <= '0;
            ers_all  <= 1'b0;
        end else begin
            case (st)
                M_READ: begin
                    if (p_start) st <= M_PBUSY;
                    else if (e_start) begin
                        st       <= M_EBUSY;
                        ers_sect <= wr_addr[ADDR_W-1:SECT_LSB];
                        ers_all  <= cmd.chip_erase;
                    end else if (cmd.ident) st <= M_IDENT;
                    else if (held && cmd.resume) begin
                        st   <= M_EBUSY;
                        held <= 1'b0;
                    end
                end
                M_IDENT: if (cmd.reset) st <= M_READ;
                M_PBUSY: begin
                    if (p_tmo)       st <= M_FAULT;
                    else if (p_done) st <= M_READ;
                end
                M_EBUSY: begin
                    if (e_tmo)       st <= M_FAULT;
                    else if (e_done) st <= M_READ;
                    else if (cmd.susp) begin
                        st   <= M_READ;
                        held <= 1'b1;
                    end
                end
                M_FAULT: if (cmd.reset) st <= M_READ;
                default: st <= M_READ;
            endcase
        end
    end

    // Read source and status outputs.
    always_comb begin
        busy       = p_run || (e_run && st == M_EBUSY);
        op_fault   = (st == M_FAULT);
        erase_held = held;
        case (st)
            M_IDENT: rd_sel = RD_IDENT;
            M_READ:  rd_sel = (held && (ers_all || rd_sect == ers_sect)) ? RD_STATUS : RD_ARRAY;
            default: rd_sel = RD_STATUS;
        endcase
    end

    // R2: busy only while a busy mode is active.
    a_r2_busy_in_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st == M_PBUSY || st == M_EBUSY));
    // R5: reset write cannot end a running program.
    a_r5_reset_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_PBUSY && wr_en && wr_data == D_RESET && !force_timeout && !p_done)
        |=> (st == M_PBUSY));
    // R6: identification is left only by a reset write.
    a_r6_ident_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_IDENT && !(wr_en && wr_data == D_RESET)) |=> (st == M_IDENT));
    // R7: fault is left only by a reset write.
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_FAULT && !(wr_en && wr_data == D_RESET)) |=> (st == M_FAULT));
    // R12: timeout wins over completion.
    a_r12_timeout_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == M_PBUSY && force_timeout && p_run) |=> (st == M_FAULT));
    // R9: a paused erase never counts.
    a_r9_held_not_erasing: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (st != M_EBUSY));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PROG_CYC   = 6;
    localparam int ERASE_CYC  = 20;
    localparam int NROW       = 28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_sect = '0;
    logic        force_timeout = 1'b0;
    logic [1:0]  rd_sel;
    logic        busy, op_fault, erase_held;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    flash_cmd_ctrl #(.ADDR_W(12), .SECT_W(3), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_sect (rd_sect), .force_timeout (force_timeout),
        .rd_sel (rd_sel), .busy (busy), .op_fault (op_fault), .erase_held (erase_held)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Row: {addr, data, expected rd_sel, expected busy}; covers R3, R4, R6.
    localparam logic [22:0] TBL [NROW] = '{
        {12'h555, 8'hAA, 2'd0, 1'b0}, {12'h2AA, 8'h55, 2'd0, 1'b0},
        {12'h555, 8'h12, 2'd0, 1'b0}, {12'h555, 8'hA0, 2'd0, 1'b0},
        {12'h123, 8'h77, 2'd0, 1'b0}, {12'h555, 8'hAA, 2'd0, 1'b0},
        {12'h2AA, 8'h55, 2'd0, 1'b0}, {12'h7FF, 8'hF0, 2'd0, 1'b0},
        {12'h555, 8'hA0, 2'd0, 1'b0}, {12'h040, 8'h99, 2'd0, 1'b0},
        {12'h555, 8'hAA, 2'd0, 1'b0}, {12'h2AA, 8'h55, 2'd0, 1'b0},
        {12'h555, 8'hA0, 2'd0, 1'b0}, {12'h000, 8'hF0, 2'd0, 1'b0},
        {12'h010, 8'h33, 2'd0, 1'b0}, {12'h555, 8'hAA, 2'd0, 1'b0},
        {12'h2AA, 8'h55, 2'd0, 1'b0}, {12'h555, 8'h90, 2'd2, 1'b0},
        {12'h345, 8'h12, 2'd2, 1'b0}, {12'h555, 8'hAA, 2'd2, 1'b0},
        {12'h2AA, 8'h55, 2'd2, 1'b0}, {12'h555, 8'hA0, 2'd2, 1'b0},
        {12'h100, 8'h44, 2'd2, 1'b0}, {12'hABC, 8'hF0, 2'd0, 1'b0},
        {12'h2AA, 8'hAA, 2'd0, 1'b0}, {12'h2AA, 8'h55, 2'd0, 1'b0},
        {12'h555, 8'hA0, 2'd0, 1'b0}, {12'h200, 8'h11, 2'd0, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic erase_seq(input logic [11:0] a, input logic [7:0] d);
        unlock(); wr(12'h555, 8'h80); unlock(); wr(a, d);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!fin) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_sel", rd_sel, 0);
        check("R1 busy", busy, 0);
        check("R1 fault", op_fault, 0);
        check("R1 held", erase_held, 0);

        // Table walk: R3, R4, R6
        for (int i = 0; i < NROW; i++) begin
            wr(TBL[i][22:11], TBL[i][10:3]);
            check($sformatf("table(R3,R4,R6) row %0d rd_sel", i), rd_sel, int'(TBL[i][2:1]));
            check($sformatf("table(R3,R4,R6) row %0d busy", i), busy, int'(TBL[i][0]));
        end

        // R2 program
        unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'h5A);
        check("R2 status while busy", rd_sel, 1);
        wait_idle(n);
        check("R2 program cycles", n, PROG_CYC);
        check("R2 back to array", rd_sel, 0);

        // R5 reset ignored while busy
        unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'h5A);
        wr(12'h000, 8'hF0);
        check("R5 still busy", busy, 1);
        wait_idle(n);
        check("R5 remaining cycles", n, PROG_CYC - 1);

        // R7 forced timeout
        unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'h5A);
        force_timeout = 1'b1; @(negedge clk); force_timeout = 1'b0;
        check("R7 fault", op_fault, 1);
        check("R7 busy off", busy, 0);
        check("R7 status", rd_sel, 1);
        unlock(); wr(12'h555, 8'hA0); wr(12'h100, 8'h22);
        check("R7 writes ignored fault", op_fault, 1);
        check("R7 writes ignored busy", busy, 0);
        wr(12'h3C3, 8'hF0);
        check("R7 reset clears fault", op_fault, 0);
        check("R7 reset array", rd_sel, 0);

        // R8 sector and chip erase
        erase_seq(12'h600, 8'h30);
        check("R8 sector erase busy", busy, 1);
        wait_idle(n);
        check("R8 sector erase cycles", n, ERASE_CYC);
        erase_seq(12'h555, 8'h10);
        wait_idle(n);
        check("R8 chip erase cycles", n, ERASE_CYC);

        // R9 pause of sector erase (sector 3)
        erase_seq(12'h600, 8'h30);
        repeat (4) @(negedge clk);
        unlock(); wr(12'h555, 8'hB0);
        check("R9 busy off", busy, 0);
        check("R9 held", erase_held, 1);
        rd_sect = 3'd3; #1;
        check("R9 erased sector status", rd_sel, 1);
        rd_sect = 3'd1; #1;
        check("R9 other sector array", rd_sel, 0);

        // R13 erase ignored while paused
        erase_seq(12'h000, 8'h30);
        check("R13 erase ignored busy", busy, 0);
        check("R13 erase ignored held", erase_held, 1);

        // R11 program inside pause
        unlock(); wr(12'h555, 8'hA0); wr(12'h200, 8'h66);
        wait_idle(n);
        check("R11 program cycles", n, PROG_CYC);
        check("R11 still held", erase_held, 1);
        rd_sect = 3'd3; #1;
        check("R11 erased sector status", rd_sel, 1);

        // R13 identification inside pause
        unlock(); wr(12'h555, 8'h90);
        check("R13 ident", rd_sel, 2);
        wr(12'h000, 8'hF0);
        check("R13 back to held", erase_held, 1);
        check("R13 erased sector status", rd_sel, 1);
        rd_sect = 3'd0; #1;
        check("R13 other sector array", rd_sel, 0);

        // R10 resume, remaining cycles
        unlock(); wr(12'h555, 8'h30);
        check("R10 busy again", busy, 1);
        check("R10 held cleared", erase_held, 0);
        wait_idle(n);
        check("R10 remaining cycles", n, ERASE_CYC - 7);

        // R9 chip erase pause covers every sector
        erase_seq(12'h555, 8'h10);
        repeat (2) @(negedge clk);
        unlock(); wr(12'h555, 8'hB0);
        rd_sect = 3'd0; #1;
        check("R9 chip sector 0 status", rd_sel, 1);
        rd_sect = 3'd7; #1;
        check("R9 chip sector 7 status", rd_sel, 1);
        unlock(); wr(12'h555, 8'h30);
        wait_idle(n);
        check("R10 chip done held", erase_held, 0);
        check("R10 chip done array", rd_sel, 0);

        // R12 timeout on the completing edge
        unlock(); wr(12'h555, 8'hA0); wr(12'h321, 8'h5A);
        repeat (PROG_CYC - 1) @(negedge clk);
        force_timeout = 1'b1; @(negedge clk); force_timeout = 1'b0;
        check("R12 timeout wins fault", op_fault, 1);
        check("R12 timeout wins status", rd_sel, 1);
        wr(12'h000, 8'hF0);

        // R12 pause on the completing edge
        erase_seq(12'h600, 8'h30);
        repeat (ERASE_CYC - 3) @(negedge clk);
        unlock(); wr(12'h555, 8'hB0);
        rd_sect = 3'd3; #1;
        check("R12 completion wins held", erase_held, 0);
        check("R12 completion wins busy", busy, 0);
        check("R12 completion wins array", rd_sel, 0);

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule